// File: doc/BRIEF.md
# Switch Reset Propagation Controller

This block decides how reset spreads through a packet switch that has one upstream port and a parameterised number of downstream ports. It watches for a hot reset or a link-down event on the upstream link. It also watches the secondary-bus-reset control bit of the upstream bridge and one such bit for each downstream bridge. From these inputs it drives an internal switch reset, a reset command and an in-band hot-reset request for each downstream port, a one-cycle configuration-reinitialise pulse, a queue-drain request and a traffic-drop enable.

An upstream event that is not masked by the hot-reset disable bit resets the switch core and every downstream port for at least `MIN_HOLD` cycles. The upstream bridge's bit resets all downstream ports but leaves the switch core alone. A downstream bridge's bit resets only its own port. Every reset that software controls lasts exactly as long as its bit stays set. Queue draining works as it does when a link goes inactive: the request is raised when reset begins and stays up until the queue logic acknowledges it.

Top module: `sw_rst_prop`

## Requirements
- R1: While `hr_disable` is 1, an upstream hot reset (`up_hot_rst`) causes no internal reset, no port reset and no downstream hot-reset request.
- R2: While `hr_disable` is 1, an upstream link-down event (`up_link_down`) causes no internal reset and no downstream hot-reset request.
- R3: While `hr_disable` is 0, `up_hot_rst` or `up_link_down` raises `int_rst`, every `port_rst` bit and every `hot_rst_req` bit. A one-cycle event keeps them high for exactly `MIN_HOLD` cycles. An event held for k cycles keeps them high for `MIN_HOLD`+k-1 cycles.
- R4: `up_sbr` = 1 puts every downstream port into reset and raises every hot-reset request, for as long as the bit stays 1. `int_rst` stays 0.
- R5: `ds_sbr[i]` = 1 resets port i only. No other port's reset, hot-reset, drain or drop output changes.
- R6: Every output is registered. A change on an input sampled at a clock edge shows on the outputs right after that same edge.
- R7: `cfg_reinit[i]` is a single-cycle pulse in the first cycle that `port_rst[i]` is 0 after being 1. It does not pulse while any reset source still holds the port.
- R8: `drain_req[i]` goes to 1 in the cycle `port_rst[i]` rises. It stays 1 until `drain_ack[i]` is sampled at 1. If a new reset rise and an acknowledge arrive in the same cycle, the request stays 1.
- R9: `drop_en[i]` is 1 whenever `port_rst[i]` or `drain_req[i]` is 1, and 0 otherwise.
- R10: After synchronous reset `rst`, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hr_disable | input | 1 | Mask for upstream hot-reset and link-down events |
| up_hot_rst | input | 1 | Hot reset received on the upstream link |
| up_link_down | input | 1 | Upstream link-down event |
| up_sbr | input | 1 | Secondary-bus-reset bit of the upstream bridge |
| ds_sbr | input | N_DS | Secondary-bus-reset bit of each downstream bridge |
| drain_ack | input | N_DS | Queue logic reports that the port's queues are empty |
| int_rst | output | 1 | Internal switch-core reset |
| port_rst | output | N_DS | Reset command for each downstream port |
| hot_rst_req | output | N_DS | In-band hot-reset request for each downstream link |
| cfg_reinit | output | N_DS | One-cycle configuration reinitialise pulse for each port |
| drain_req | output | N_DS | Queue-drain request for each port |
| drop_en | output | N_DS | Drop incoming traffic for each port |

## Verification
Two events can land on the same edge. The first is the rising edge of a new reset on a port. The second is the acknowledge for a drain that an earlier reset on that port left pending. The bench holds back `drain_ack` so that the drain stays pending across a reset that has ended, then re-asserts that port's bit together with the acknowledge. It expects `drain_req` to stay high, and to clear only on a later acknowledge that has no rise with it. The bench also runs an upstream hot reset to the end of its hold while `up_sbr` is still set. It expects no `cfg_reinit` pulse at that point, and a pulse on every port only once the bit is cleared.

// File: rtl/sw_rst_pkg.sv
package sw_rst_pkg;

  // Per-port registered outputs, grouped.
  typedef struct packed {
    logic rst;
    logic hot_req;
    logic cfg_reinit;
    logic drain_req;
    logic drop_en;
  } port_out_t;

endpackage

// File: rtl/sw_rst_hold.sv
module sw_rst_hold #(
  parameter int MIN_HOLD = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic hot_rst,
  input  logic link_down,
  input  logic disable_i,
  output logic hold_next,
  output logic hold_q
);

  localparam int CW = $clog2(MIN_HOLD + 1);
  localparam logic [CW-1:0] LOAD = CW'(MIN_HOLD - 1);

  logic          trig;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  assign trig = (hot_rst | link_down) & ~disable_i;

  always_comb begin
    cnt_d     = cnt_q;
    hold_next = 1'b0;
    if (trig) begin
      cnt_d     = LOAD;
      hold_next = 1'b1;
    end else if (cnt_q != '0) begin
      cnt_d     = cnt_q - 1'b1;
      hold_next = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      hold_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      hold_q <= hold_next;
    end
  end

  // Run-length counter kept only for the minimum-hold check.
  localparam int RW = CW + 1;
  logic [RW-1:0] run_q;
  always_ff @(posedge clk) begin
    if (rst)                         run_q <= '0;
    else if (!hold_q)                run_q <= '0;
    else if (run_q != {RW{1'b1}})    run_q <= run_q + 1'b1;
  end

  // R1 / R2: a masked event never starts the internal reset
  p_masked_event_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(hold_q) |-> ($past(!disable_i) && $past(hot_rst || link_down)));

  // R3: the internal reset lasts at least MIN_HOLD cycles
  p_min_hold_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(hold_q) |-> (run_q >= RW'(MIN_HOLD)));

  // R3: an unmasked event is followed by the internal reset
  p_event_starts_r3: assert property (@(posedge clk) disable iff (rst)
    ((hot_rst || link_down) && !disable_i) |=> hold_q);

endmodule

// File: rtl/sw_rst_port.sv
module sw_rst_port
  import sw_rst_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      src_glob,
  input  logic      src_up,
  input  logic      src_own,
  input  logic      drain_ack,
  output port_out_t o
);

  logic src;
  logic rise;
  logic drain_d;

  assign src     = src_glob | src_up | src_own;
  assign rise    = src & ~o.rst;
  // A new reset rise takes priority over a pending acknowledge.
  assign drain_d = rise | (o.drain_req & ~drain_ack);

  always_ff @(posedge clk) begin
    if (rst) begin
      o <= '0;
    end else begin
      o.rst        <= src;
      o.hot_req    <= src;
      o.cfg_reinit <= o.rst & ~src;
      o.drain_req  <= drain_d;
      o.drop_en    <= src | drain_d;
    end
  end

  // R4 / R5: a software bit keeps the port in reset
  p_sbr_holds_r4: assert property (@(posedge clk) disable iff (rst)
    (src_up || src_own) |=> (o.rst && o.hot_req));

  // R7: the reinitialise strobe lasts one cycle
  p_cfg_single_r7: assert property (@(posedge clk) disable iff (rst)
    o.cfg_reinit |=> !o.cfg_reinit);

  // R7: the strobe follows the end of the port reset
  p_cfg_after_rst_r7: assert property (@(posedge clk) disable iff (rst)
    o.cfg_reinit |-> (!o.rst && $past(o.rst)));

  // R8: the drain request comes up with the reset
  p_drain_on_rise_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(o.rst) |-> o.drain_req);

  // R9: traffic is dropped while reset or drain is active
  p_drop_cover_r9: assert property (@(posedge clk) disable iff (rst)
    (o.rst || o.drain_req) |-> o.drop_en);

endmodule

// File: rtl/sw_rst_prop.sv
module sw_rst_prop
  import sw_rst_pkg::*;
#(
  parameter int N_DS     = 4,
  parameter int MIN_HOLD = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            hr_disable,
  input  logic            up_hot_rst,
  input  logic            up_link_down,
  input  logic            up_sbr,
  input  logic [N_DS-1:0] ds_sbr,
  input  logic [N_DS-1:0] drain_ack,
  output logic            int_rst,
  output logic [N_DS-1:0] port_rst,
  output logic [N_DS-1:0] hot_rst_req,
  output logic [N_DS-1:0] cfg_reinit,
  output logic [N_DS-1:0] drain_req,
  output logic [N_DS-1:0] drop_en
);

  logic glob_next;

  sw_rst_hold #(.MIN_HOLD(MIN_HOLD)) u_hold (
    .clk       (clk),
    .rst       (rst),
    .hot_rst   (up_hot_rst),
    .link_down (up_link_down),
    .disable_i (hr_disable),
    .hold_next (glob_next),
    .hold_q    (int_rst)
  );

  for (genvar g = 0; g < N_DS; g++) begin : g_port
    port_out_t po;

    sw_rst_port u_port (
      .clk       (clk),
      .rst       (rst),
      .src_glob  (glob_next),
      .src_up    (up_sbr),
      .src_own   (ds_sbr[g]),
      .drain_ack (drain_ack[g]),
      .o         (po)
    );

    assign port_rst[g]    = po.rst;
    assign hot_rst_req[g] = po.hot_req;
    assign cfg_reinit[g]  = po.cfg_reinit;
    assign drain_req[g]   = po.drain_req;
    assign drop_en[g]     = po.drop_en;
  end

  // R4: the upstream bridge bit never resets the switch core
  p_core_untouched_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(int_rst) |-> $past(up_hot_rst || up_link_down));

  // R3: the core reset and the port resets go together
  p_glob_all_ports_r3: assert property (@(posedge clk) disable iff (rst)
    int_rst |-> (&port_rst));

endmodule

// File: tb/sw_rst_prop_bench.sv
module sw_rst_prop_bench;

  localparam int N  = 4;
  localparam int MH = 16;

  logic clk = 1'b0;
  logic rst;
  logic hr_disable, up_hot_rst, up_link_down, up_sbr;
  logic [N-1:0] ds_sbr, drain_ack;
  logic int_rst;
  logic [N-1:0] port_rst, hot_rst_req, cfg_reinit, drain_req, drop_en;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  sw_rst_prop #(.N_DS(N), .MIN_HOLD(MH)) u_sw_rst_prop (
    .clk(clk), .rst(rst), .hr_disable(hr_disable), .up_hot_rst(up_hot_rst),
    .up_link_down(up_link_down), .up_sbr(up_sbr), .ds_sbr(ds_sbr),
    .drain_ack(drain_ack), .int_rst(int_rst), .port_rst(port_rst),
    .hot_rst_req(hot_rst_req), .cfg_reinit(cfg_reinit), .drain_req(drain_req),
    .drop_en(drop_en)
  );

  // Stimulus {hr_disable, up_hot_rst, up_link_down, up_sbr, ds_sbr[3:0]}
  // Expected {int_rst, port_rst, cfg_reinit, drain_req, drop_en}, drain_ack = 1111
  localparam int NV = 11;
  localparam logic [24:0] VEC [NV] = '{
    {8'b0000_0001, 17'b0_0001_0000_0001_0001},
    {8'b0000_0001, 17'b0_0001_0000_0000_0001},
    {8'b0000_0100, 17'b0_0100_0001_0100_0100},
    {8'b0001_0100, 17'b0_1111_0000_1011_1111},
    {8'b0001_0000, 17'b0_1111_0000_0000_1111},
    {8'b0000_1000, 17'b0_1000_0111_0000_1000},
    {8'b0000_0000, 17'b0_0000_1000_0000_0000},
    {8'b0000_0000, 17'b0_0000_0000_0000_0000},
    {8'b1100_0000, 17'b0_0000_0000_0000_0000},
    {8'b1010_0010, 17'b0_0010_0000_0010_0010},
    {8'b0000_0000, 17'b0_0000_0010_0000_0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [7:0] s);
    {hr_disable, up_hot_rst, up_link_down, up_sbr, ds_sbr} = s;
  endtask

  function automatic logic [16:0] outs();
    return {int_rst, port_rst, cfg_reinit, drain_req, drop_en};
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int cnt;
    rst = 1'b1;
    drive(8'h00);
    drain_ack = '1;
    repeat (3) @(negedge clk);
    // R10: all outputs cleared by reset
    chk("R10 reset state", {15'd0, outs()}, 32'd0);
    chk("R10 hot_rst_req reset", {28'd0, hot_rst_req}, 32'd0);
    rst = 1'b0;
    @(negedge clk);

    // Table walk: R1 R2 R4 R5 R6 R7 R9
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][24:17]);
      @(negedge clk);
      chk($sformatf("R5/R6/R7 vector %0d", i), {15'd0, outs()}, {15'd0, VEC[i][16:0]});
      chk($sformatf("R4 hot_rst_req vector %0d", i), {28'd0, hot_rst_req},
          {28'd0, VEC[i][15:12]});
    end

    // R3: one-cycle hot reset, not masked
    drive(8'b0100_0000);
    @(negedge clk);
    drive(8'h00);
    chk("R3 hot reset reaches ports", {27'd0, int_rst, hot_rst_req}, {27'd0, 5'b1_1111});
    cnt = 1;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (!int_rst) break;
      cnt++;
    end
    chk("R3 hold length one-cycle event", cnt, MH);
    chk("R7 reinit after global reset", {28'd0, cfg_reinit}, 32'hF);
    @(negedge clk);
    chk("R7 reinit single cycle", {28'd0, cfg_reinit}, 32'h0);

    // R3: link-down held three cycles
    drive(8'b0010_0000);
    repeat (3) @(negedge clk);
    drive(8'h00);
    cnt = 3;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (!int_rst) break;
      cnt++;
    end
    chk("R3 hold length held event", cnt, MH + 2);

    // R2: masked link-down held several cycles
    drive(8'b1010_0000);
    repeat (3) @(negedge clk);
    chk("R2 masked link-down", {27'd0, int_rst, hot_rst_req}, 32'd0);
    drive(8'h00);
    @(negedge clk);

    // R4 with global overlap: no reinit while up_sbr holds
    drive(8'b0101_0000);
    @(negedge clk);
    drive(8'b0001_0000);
    cnt = 0;
    repeat (MH + 4) begin
      @(negedge clk);
      if (cfg_reinit != '0 || port_rst != '1) cnt++;
    end
    chk("R4 up_sbr holds through global end", cnt, 0);
    chk("R4 core reset released", {31'd0, int_rst}, 32'd0);
    drive(8'h00);
    @(negedge clk);
    chk("R7 reinit after up_sbr clear", {28'd0, cfg_reinit}, 32'hF);

    // R8: drain held until acknowledged; rise beats ack in the same cycle
    drain_ack = 4'b0000;
    drive(8'b0000_0001);
    @(negedge clk);
    chk("R8 drain raised", {28'd0, drain_req}, 32'h1);
    drive(8'h00);
    @(negedge clk);
    chk("R8 drain pending after reset end", {28'd0, drain_req}, 32'h1);
    chk("R9 drop while drain pending", {28'd0, drop_en}, 32'h1);
    chk("R7 reinit with drain pending", {28'd0, cfg_reinit}, 32'h1);
    drive(8'b0000_0001);
    drain_ack = 4'b0001;
    @(negedge clk);
    chk("R8 rise wins over ack", {28'd0, drain_req}, 32'h1);
    @(negedge clk);
    chk("R8 ack clears drain", {28'd0, drain_req}, 32'h0);
    chk("R9 drop follows held reset", {28'd0, drop_en}, 32'h1);
    drive(8'h00);
    @(negedge clk);
    chk("R9 drop released", {28'd0, drop_en}, 32'h0);

    // R10: reset in the middle of activity
    drive(8'b0001_1111);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R10 reset clears active state", {15'd0, outs()}, 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule